// File: doc/BRIEF.md
# VGA 640x400 Sync Timing Generator

This block produces the raster timing for a 640x400 picture refreshed at roughly 70 Hz from a 25 MHz pixel clock. A pixel counter steps through the 800 clocks of each scan line. A line counter, paired with a small vertical phase machine, steps through the 449 lines of each frame. From these the block derives a low-going horizontal sync, a high-going vertical sync, a flag for lines that carry picture, and one-clock strobes at the start of every line and every frame. A downstream line serializer uses these to fetch and shift out pixel data.

The vertical phase machine has five states. `VP_LEAD` covers the lines before vertical sync. `VP_SYNC` holds while vertical sync is driven. `VP_BACK` covers the blank lines between sync and picture. `VP_SHOW` covers the 400 picture lines. `VP_TAIL` covers the blank lines after the picture. The machine moves only when the pixel counter wraps, and each move is decided by the line number being entered:

- `LEAD→SYNC` on entering line 2.
- `SYNC→BACK` on entering line 4.
- `BACK→SHOW` on entering line 38.
- `SHOW→TAIL` on entering line 438.
- `TAIL→LEAD` on entering line 0.

Reset forces `VP_LEAD`. All geometry values are parameters whose defaults give the mode above. The timing is fixed at build time.

Top module: `vga400_timing`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become `hsync_n`=1, `vsync`=0, `visible`=0, `line_start`=0 and `frame_start`=0, and both counters go to 0. The cycle in which reset is released is position 0, and each later rising edge advances the position by one.
- R2: A line lasts 800 clocks. `line_start` is high for exactly one clock whenever the pixel position returns from 799 to 0. It is never high at position 0 directly after reset.
- R3: `hsync_n` is 0 exactly for pixel positions 16 through 47 of every line (32 clocks), and 1 for all other positions.
- R4: `vsync` is 1 exactly during lines 2 and 3 of the frame, and 0 on all other lines.
- R5: `visible` is 1 exactly during lines 38 through 437 (400 lines). It is never 1 together with `vsync`.
- R6: A frame lasts 449 lines. `frame_start` is high for one clock, on the first clock of line 0 reached by wrapping from line 448, and always together with `line_start`.
- R7: All outputs are registered. `vsync` and `visible` change value only in a cycle where `line_start` is 1.
- R8: Asserting `rst` in the middle of a frame returns all outputs to the R1 values, and after release the timing restarts from position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active high |
| visible | output | 1 | High on lines that carry picture |
| line_start | output | 1 | One-clock strobe on the first clock of each line |
| frame_start | output | 1 | One-clock strobe on the first clock of each frame |

## Verification
The bench predicts every output on every clock from the position counted since reset release. This catches off-by-one errors at every edge:

- A sync that opens at pixel 15, or closes at pixel 48 instead of 47, shows as a mismatch on a single clock.
- A phase machine that decides on the line being left rather than the line being entered shifts vertical sync or the picture window by one whole line.

A full 449-line frame is too long for a default-sized run, so a second instance with a scaled-down geometry runs through many frame wraps. There, a counter that wraps at 448 or 450 lines, or a frame strobe missing its line strobe, is caught. A reset applied mid-frame checks that no stale phase state survives; a design that did not clear the phase machine would raise `vsync` or `visible` on the wrong lines after release.

// File: rtl/vga400_pkg.sv
package vga400_pkg;

    // Vertical phase of the raster
    typedef enum logic [2:0] {
        VP_LEAD = 3'd0,
        VP_SYNC = 3'd1,
        VP_BACK = 3'd2,
        VP_SHOW = 3'd3,
        VP_TAIL = 3'd4
    } vphase_e;

endpackage

// File: rtl/vga400_hcount.sv
module vga400_hcount #(
    parameter int H_TOTAL = 800,
    localparam int PW = $clog2(H_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] pix_d,
    output logic          wrap
);

    logic [PW-1:0] pix_q;

    always_comb begin
        wrap = (pix_q == PW'(H_TOTAL - 1));
        if (rst) begin
            pix_d = '0;
        end else if (wrap) begin
            pix_d = '0;
        end else begin
            pix_d = pix_q + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        pix_q <= pix_d;
    end

endmodule

// File: rtl/vga400_vphase.sv
module vga400_vphase
    import vga400_pkg::*;
#(
    parameter int V_TOTAL   = 449,
    parameter int VS_START  = 2,
    parameter int VS_END    = 4,
    parameter int VIS_START = 38,
    parameter int VIS_END   = 438,
    localparam int LW = $clog2(V_TOTAL)
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    adv,
    output vphase_e phase_d,
    output logic    last_line
);

    logic [LW-1:0] line_q;
    logic [LW-1:0] line_d;
    vphase_e       phase_q;

    // Line counter, advanced on each pixel wrap
    always_comb begin
        last_line = (line_q == LW'(V_TOTAL - 1));
        if (rst) begin
            line_d = '0;
        end else if (adv) begin
            line_d = last_line ? '0 : line_q + LW'(1);
        end else begin
            line_d = line_q;
        end
    end

    // Next phase, decided by the line about to be entered
    always_comb begin
        phase_d = phase_q;
        if (rst) begin
            phase_d = VP_LEAD;
        end else if (adv) begin
            unique case (phase_q)
                VP_LEAD: if (line_d == LW'(VS_START))  phase_d = VP_SYNC;
                VP_SYNC: if (line_d == LW'(VS_END))    phase_d = VP_BACK;
                VP_BACK: if (line_d == LW'(VIS_START)) phase_d = VP_SHOW;
                VP_SHOW: if (line_d == LW'(VIS_END))   phase_d = VP_TAIL;
                VP_TAIL: if (line_d == '0)             phase_d = VP_LEAD;
                default: phase_d = VP_LEAD;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        line_q  <= line_d;
        phase_q <= phase_d;
    end

endmodule

// File: rtl/vga400_timing.sv
module vga400_timing
    import vga400_pkg::*;
#(
    parameter int H_TOTAL   = 800,
    parameter int HS_START  = 16,
    parameter int HS_END    = 48,
    parameter int V_TOTAL   = 449,
    parameter int VS_START  = 2,
    parameter int VS_END    = 4,
    parameter int VIS_START = 38,
    parameter int VIS_END   = 438
) (
    input  logic clk,
    input  logic rst,
    output logic hsync_n,
    output logic vsync,
    output logic visible,
    output logic line_start,
    output logic frame_start
);

    localparam int PW = $clog2(H_TOTAL);

    logic [PW-1:0] pix_d;
    logic          wrap;
    vphase_e       phase_d;
    logic          last_line;

    vga400_hcount #(
        .H_TOTAL (H_TOTAL)
    ) u_hcnt (
        .clk   (clk),
        .rst   (rst),
        .pix_d (pix_d),
        .wrap  (wrap)
    );

    vga400_vphase #(
        .V_TOTAL   (V_TOTAL),
        .VS_START  (VS_START),
        .VS_END    (VS_END),
        .VIS_START (VIS_START),
        .VIS_END   (VIS_END)
    ) u_vph (
        .clk       (clk),
        .rst       (rst),
        .adv       (wrap),
        .phase_d   (phase_d),
        .last_line (last_line)
    );

    // Output register: the outputs follow the counters' next values,
    // so they stay aligned with the counter state
    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_n     <= 1'b1;
            vsync       <= 1'b0;
            visible     <= 1'b0;
            line_start  <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            hsync_n     <= !((pix_d >= PW'(HS_START)) && (pix_d < PW'(HS_END)));
            vsync       <= (phase_d == VP_SYNC);
            visible     <= (phase_d == VP_SHOW);
            line_start  <= wrap;
            frame_start <= wrap && last_line;
        end
    end

endmodule

// File: rtl/vga400_timing_chk.sv
module vga400_timing_chk #(
    parameter int H_TOTAL  = 800,
    parameter int HS_START = 16,
    parameter int HS_END   = 48
) (
    input logic clk,
    input logic rst,
    input logic hsync_n,
    input logic vsync,
    input logic visible,
    input logic line_start,
    input logic frame_start
);

    logic [31:0] gap_cnt;
    logic [31:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt <= '0;
            low_cnt <= '0;
        end else begin
            gap_cnt <= line_start ? 32'd1 : gap_cnt + 32'd1;
            low_cnt <= hsync_n ? 32'd0 : low_cnt + 32'd1;
        end
    end

    // R2: line strobes spaced by the line length
    p_line_period_r2: assert property (@(posedge clk) disable iff (rst)
        line_start |-> (gap_cnt == 32'(H_TOTAL)));

    // R2: strobe lasts one clock
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !line_start);

    // R3: sync pulse width
    p_hsync_width_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_n) |-> (low_cnt == 32'(HS_END - HS_START)));

    // R5: picture never during vertical sync
    p_sync_vis_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(vsync && visible));

    // R6: frame strobe coincides with a line strobe
    p_frame_on_line_r6: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> line_start);

    // R7: vertical outputs move only at line starts
    p_vsync_align_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(vsync) |-> line_start);

    p_vis_align_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(visible) |-> line_start);

endmodule

bind vga400_timing vga400_timing_chk #(
    .H_TOTAL  (H_TOTAL),
    .HS_START (HS_START),
    .HS_END   (HS_END)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hsync_n     (hsync_n),
    .vsync       (vsync),
    .visible     (visible),
    .line_start  (line_start),
    .frame_start (frame_start)
);

// File: tb/sim_vga400_timing.sv
module sim_vga400_timing;

    // Full-size geometry
    localparam int A_H = 800, A_HS0 = 16, A_HS1 = 48;
    localparam int A_V = 449, A_VS0 = 2, A_VS1 = 4, A_VA0 = 38, A_VA1 = 438;
    // Scaled geometry for frame wrap coverage
    localparam int B_H = 40, B_HS0 = 4, B_HS1 = 12;
    localparam int B_V = 20, B_VS0 = 2, B_VS1 = 4, B_VA0 = 6, B_VA1 = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_hs, a_vs, a_vi, a_ls, a_fs;
    logic b_hs, b_vs, b_vi, b_ls, b_fs;

    int checks = 0;
    int fails  = 0;
    int pos    = 0;
    logic prev_vs = 1'b0;
    logic prev_vi = 1'b0;

    always #5 clk = ~clk;

    vga400_timing #(
        .H_TOTAL(A_H), .HS_START(A_HS0), .HS_END(A_HS1),
        .V_TOTAL(A_V), .VS_START(A_VS0), .VS_END(A_VS1),
        .VIS_START(A_VA0), .VIS_END(A_VA1)
    ) u0 (
        .clk(clk), .rst(rst), .hsync_n(a_hs), .vsync(a_vs),
        .visible(a_vi), .line_start(a_ls), .frame_start(a_fs)
    );

    vga400_timing #(
        .H_TOTAL(B_H), .HS_START(B_HS0), .HS_END(B_HS1),
        .V_TOTAL(B_V), .VS_START(B_VS0), .VS_END(B_VS1),
        .VIS_START(B_VA0), .VIS_END(B_VA1)
    ) u1 (
        .clk(clk), .rst(rst), .hsync_n(b_hs), .vsync(b_vs),
        .visible(b_vi), .line_start(b_ls), .frame_start(b_fs)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at position %0d: got %b expected %b", tag, what, pos, act, exp);
        end
    endtask

    // Predict outputs at position n for a given geometry
    task automatic cmp(input string who, input int n,
                       input int h, input int hs0, input int hs1,
                       input int v, input int vs0, input int vs1,
                       input int va0, input int va1,
                       input logic hs, input logic vs, input logic vi,
                       input logic ls, input logic fs);
        int px = n % h;
        int ln = (n / h) % v;
        logic e_ls = (px == 0) && (n > 0);
        chk("R3", {who, " hsync_n"}, hs, !((px >= hs0) && (px < hs1)));
        chk("R4", {who, " vsync"}, vs, (ln >= vs0) && (ln < vs1));
        chk("R5", {who, " visible"}, vi, (ln >= va0) && (ln < va1));
        chk("R2", {who, " line_start"}, ls, e_ls);
        chk("R6", {who, " frame_start"}, fs, e_ls && (ln == 0));
    endtask

    task automatic check_reset_vals(input string tag);
        chk(tag, "u0 hsync_n", a_hs, 1'b1);
        chk(tag, "u0 vsync", a_vs, 1'b0);
        chk(tag, "u0 visible", a_vi, 1'b0);
        chk(tag, "u0 line_start", a_ls, 1'b0);
        chk(tag, "u0 frame_start", a_fs, 1'b0);
        chk(tag, "u1 hsync_n", b_hs, 1'b1);
        chk(tag, "u1 vsync", b_vs, 1'b0);
        chk(tag, "u1 line_start", b_ls, 1'b0);
        chk(tag, "u1 frame_start", b_fs, 1'b0);
    endtask

    // Scenario: reset state (R1)
    task automatic t_reset_state();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        pos = 0;
        prev_vs = 1'b0;
        prev_vi = 1'b0;
        check_reset_vals("R1");
    endtask

    // Scenario: free run, every output predicted every clock (R2-R7)
    task automatic t_run(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            pos++;
            @(negedge clk);
            cmp("u0", pos, A_H, A_HS0, A_HS1, A_V, A_VS0, A_VS1, A_VA0, A_VA1,
                a_hs, a_vs, a_vi, a_ls, a_fs);
            cmp("u1", pos, B_H, B_HS0, B_HS1, B_V, B_VS0, B_VS1, B_VA0, B_VA1,
                b_hs, b_vs, b_vi, b_ls, b_fs);
            // R7: vertical outputs change only with a line strobe
            if ((a_vs !== prev_vs) || (a_vi !== prev_vi))
                chk("R7", "u0 vertical change without line_start", a_ls, 1'b1);
            prev_vs = a_vs;
            prev_vi = a_vi;
        end
    endtask

    // Scenario: reset in the middle of a frame (R8)
    task automatic t_midrun_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_reset_vals("R8");
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        pos = 0;
        prev_vs = 1'b0;
        prev_vi = 1'b0;
        check_reset_vals("R8");
        t_run(2500);
    endtask

    initial begin
        t_reset_state();
        t_run(34000);
        t_midrun_reset();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule